// File: doc/BRIEF.md
# Two-Line Coprocessor Host Mailbox

This block connects an 8-bit PC-style I/O bus to an attached coprocessor over four wires: two host-to-coprocessor data lines, a coprocessor reset line and one return line. A 4-bit switch value places a two-port I/O window in the 10-bit host I/O space. A host write to the first port of the window sets both data lines and the reset line. A host read of the second port reports the return bit in inverted form.

On the coprocessor side, the block exposes one memory-mapped register. The register answers at every word-aligned address inside a 4 MB mirrored region. Reading it shows the two host data lines. Writing it captures the return bit, which also leaves the block as a busy/data-out signal. Host data line 1 also drives the coprocessor's fast-interrupt request. That makes it the signalling line of the link.

Top module: `copro_link_mailbox`

## Requirements
- R1: After reset, both data lines, the coprocessor reset output, the fast-interrupt request and the return bit (busy output) are all 0.
- R2: The window base is switch value × 0x40 + 0x10, which gives 0x010 for value 0 and 0x3D0 for value 15. A host access matches only when `isa_aen` is low and address bits 9:1 equal base bits 9:1. Address bit 0 selects the port: 0 is the control port and 1 is the status port.
- R3: A host write to the control port takes effect at the clock edge where `isa_iow_n` is sampled high after being sampled low, with the address still matching. It loads data bit 0 into data line 0, data bit 7 into data line 1 and data bit 1 into the coprocessor reset output. The outputs show the new values from that edge on.
- R4: Host writes to the status port, to any address outside the window, or with `isa_aen` high leave all lines unchanged.
- R5: While a host read matches, `isa_drive` is 1. The status port returns 0x00 when the return bit is 1 and 0x80 when it is 0. The control port returns 0xFF. When no read matches, `isa_drive` is 0 and `isa_dout` is 0x00.
- R6: `cp_firq` always equals data line 1.
- R7: The coprocessor register hits when (`cp_addr` AND NOT 0x003FFFFC) equals 0x00400000. On a hit, `cp_rdata` has data line 0 in bit 0, data line 1 in bit 7 and zeros in bits 6:1. On a miss it is 0x00.
- R8: A coprocessor write (`cp_wr` high) that hits stores `cp_wdata` bit 0 as the return bit on the next clock edge and drives it on `cp_busy`. A write that misses leaves the return bit unchanged.
- R9: While `isa_iow_n` stays low over several cycles, the lines do not change. Exactly one capture happens on release, using the data present then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dip_sel | input | 4 | Base-address switch value |
| isa_addr | input | 10 | Host I/O address |
| isa_aen | input | 1 | Address enable (high = DMA cycle, no match) |
| isa_iow_n | input | 1 | Host I/O write strobe, active low |
| isa_ior_n | input | 1 | Host I/O read strobe, active low |
| isa_din | input | 8 | Host write data |
| isa_dout | output | 8 | Host read data |
| isa_drive | output | 1 | High while the block drives the host data bus |
| cp_addr | input | 32 | Coprocessor byte address |
| cp_wr | input | 1 | Coprocessor write strobe, one cycle |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rdata | output | 8 | Coprocessor register read value |
| cp_firq | output | 1 | Fast-interrupt request to the coprocessor |
| cp_reset | output | 1 | Reset to the coprocessor |
| cp_line0 | output | 1 | Host data line 0 |
| cp_line1 | output | 1 | Host data line 1 |
| cp_busy | output | 1 | Return bit, driven out as busy/data-out |

## Verification
The bench sweeps all sixteen switch values and probes each base, both ports, the next port pair up and the window one step up. A decoder that compared address bit 0 or used a wrong multiplier would answer at the wrong port or miss its own window. It writes all 256 data values to the control port, so a swapped bit 1/bit 7 mapping or an uninverted status bit shows up at once. It also checks that AEN-high, status-port and held-strobe writes leave the lines alone. On the coprocessor side it probes the ends of the mirror, an unaligned address and neighbouring 4 MB regions. A mask that ignored the low address bits or the upper address bits would then report false hits.

// File: rtl/copro_link_mailbox.sv
module copro_link_mailbox #(
  parameter int DIP_W     = 4,
  parameter int IO_AW     = 10,
  parameter int DW        = 8,
  parameter int BASE_STEP = 'h40,
  parameter int BASE_OFS  = 'h10,
  parameter int CP_AW     = 32,
  parameter logic [CP_AW-1:0] CP_BASE   = 32'h0040_0000,
  parameter logic [CP_AW-1:0] CP_MIRROR = 32'h003F_FFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIP_W-1:0] dip_sel,
  input  logic [IO_AW-1:0] isa_addr,
  input  logic             isa_aen,
  input  logic             isa_iow_n,
  input  logic             isa_ior_n,
  input  logic [DW-1:0]    isa_din,
  output logic [DW-1:0]    isa_dout,
  output logic             isa_drive,
  input  logic [CP_AW-1:0] cp_addr,
  input  logic             cp_wr,
  input  logic [DW-1:0]    cp_wdata,
  output logic [DW-1:0]    cp_rdata,
  output logic             cp_firq,
  output logic             cp_reset,
  output logic             cp_line0,
  output logic             cp_line1,
  output logic             cp_busy
);

  localparam int L0_BIT   = 0;
  localparam int RST_BIT  = 1;
  localparam int L1_BIT   = DW - 1;
  localparam int STAT_BIT = DW - 1;
  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  logic [IO_AW-1:0] io_base;
  logic             io_match, port_ctl, port_stat;
  logic             iow_q, wr_evt, cp_hit;
  logic             line0_q, line1_q, rst_q, ret_q;
  logic             unused_bits;

  assign io_base   = IO_AW'(int'(dip_sel) * BASE_STEP + BASE_OFS);
  assign io_match  = !isa_aen && (isa_addr[IO_AW-1:1] == io_base[IO_AW-1:1]);
  assign port_ctl  = io_match && !isa_addr[0];
  assign port_stat = io_match &&  isa_addr[0];
  assign wr_evt    = port_ctl && isa_iow_n && !iow_q;
  assign cp_hit    = (cp_addr & ~CP_MIRROR) == CP_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iow_q   <= 1'b1;
      line0_q <= 1'b0;
      line1_q <= 1'b0;
      rst_q   <= 1'b0;
      ret_q   <= 1'b0;
    end else begin
      iow_q <= isa_iow_n;
      if (wr_evt) begin
        line0_q <= isa_din[L0_BIT];
        line1_q <= isa_din[L1_BIT];
        rst_q   <= isa_din[RST_BIT];
      end
      if (cp_wr && cp_hit)
        ret_q <= cp_wdata[0];
    end
  end

  assign isa_drive = io_match && !isa_ior_n;

  always_comb begin
    isa_dout = '0;
    if (isa_drive) begin
      if (port_stat) isa_dout[STAT_BIT] = !ret_q;
      else           isa_dout = ALL_ONES;
    end
  end

  always_comb begin
    cp_rdata = '0;
    if (cp_hit) begin
      cp_rdata[0]    = line0_q;
      cp_rdata[DW-1] = line1_q;
    end
  end

  assign cp_line0 = line0_q;
  assign cp_line1 = line1_q;
  assign cp_reset = rst_q;
  assign cp_firq  = line1_q;
  assign cp_busy  = ret_q;

  assign unused_bits = ^{isa_din[DW-2:2], cp_wdata[DW-1:1]};

  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable({cp_line0, cp_line1, cp_reset}));  // R4
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (cp_line1 == $past(isa_din[L1_BIT])) && (cp_reset == $past(isa_din[RST_BIT]))); // R3
  AST_FIRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cp_firq == cp_rdata[DW-1] || !cp_hit);  // R6
  AST_STAT_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_drive && isa_addr[0]) |-> (isa_dout[STAT_BIT] != cp_busy) && (isa_dout[STAT_BIT-1:0] == '0)); // R5
  AST_CP_ZERO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rdata[DW-2:1] == '0);  // R7
  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cp_wr && cp_hit) |=> $stable(cp_busy));  // R8
  AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr && cp_hit) |=> cp_busy == $past(cp_wdata[0]));  // R8
  AST_HELD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_iow_n && $past(!isa_iow_n)) |=> $stable({cp_line0, cp_line1, cp_reset})); // R9

endmodule

// File: tb/tb_copro_link_mailbox.sv
module tb_copro_link_mailbox;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  dip_sel = 4'd8;
  logic [9:0]  isa_addr = '0;
  logic        isa_aen = 0, isa_iow_n = 1, isa_ior_n = 1;
  logic [7:0]  isa_din = '0;
  logic [7:0]  isa_dout;
  logic        isa_drive;
  logic [31:0] cp_addr = '0;
  logic        cp_wr = 0;
  logic [7:0]  cp_wdata = '0;
  logic [7:0]  cp_rdata;
  logic        cp_firq, cp_reset, cp_line0, cp_line1, cp_busy;

  int checks = 0, failures = 0;
  bit done = 0;
  logic e_l0 = 0, e_l1 = 0, e_rst = 0, e_ret = 0;

  always #2 clk = ~clk;

  copro_link_mailbox dut (
    .clk(clk), .rst_n(rst_n), .dip_sel(dip_sel), .isa_addr(isa_addr),
    .isa_aen(isa_aen), .isa_iow_n(isa_iow_n), .isa_ior_n(isa_ior_n),
    .isa_din(isa_din), .isa_dout(isa_dout), .isa_drive(isa_drive),
    .cp_addr(cp_addr), .cp_wr(cp_wr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .cp_firq(cp_firq), .cp_reset(cp_reset), .cp_line0(cp_line0),
    .cp_line1(cp_line1), .cp_busy(cp_busy));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_lines(string req);
    chk(req, {cp_line0, cp_line1, cp_reset, cp_firq}, {e_l0, e_l1, e_rst, e_l1});
  endtask

  task automatic host_wr(logic [9:0] a, logic [7:0] d, logic aen, int hold);
    @(negedge clk);
    isa_addr = a; isa_din = d; isa_aen = aen; isa_iow_n = 0;
    for (int i = 0; i < hold; i++) @(negedge clk);
    isa_iow_n = 1;
    @(negedge clk);
    isa_aen = 0; isa_addr = '0;
  endtask

  task automatic host_rd(logic [9:0] a, output logic [7:0] d, output logic drv);
    @(negedge clk);
    isa_addr = a; isa_ior_n = 0;
    #1 d = isa_dout; drv = isa_drive;
    isa_ior_n = 1; isa_addr = '0;
  endtask

  task automatic cp_write(logic [31:0] a, logic [7:0] d);
    @(negedge clk);
    cp_addr = a; cp_wdata = d; cp_wr = 1;
    @(negedge clk);
    cp_wr = 0;
  endtask

  function automatic bit cp_hit_model(logic [31:0] a);
    return (a & ~32'h003F_FFFC) == 32'h0040_0000;
  endfunction

  initial begin
    logic [7:0] rd; logic drv;
    logic [9:0] base;
    logic [31:0] probes [8];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset lines", {cp_line0, cp_line1, cp_reset, cp_firq, cp_busy}, 0);

    for (int v = 0; v < 16; v++) begin
      dip_sel = 4'(v);
      base = 10'(v * 64 + 16);
      host_rd(base, rd, drv);      chk("R5 ctl read FF", {drv, rd}, {1'b1, 8'hFF});
      host_rd(base + 1, rd, drv);  chk("R5 stat read", {drv, rd}, {1'b1, e_ret ? 8'h00 : 8'h80});
      host_rd(base + 2, rd, drv);  chk("R2 outside +2", {drv, rd}, 0);
      host_rd(base ^ 10'h040, rd, drv); chk("R2 outside step", {drv, rd}, 0);
      host_wr(base, 8'(v * 37 + 129), 0, 1);
      e_l0 = (v * 37 + 129) % 2 == 1;
      e_rst = ((v * 37 + 129) / 2) % 2 == 1;
      e_l1 = ((v * 37 + 129) / 128) % 2 == 1;
      chk_lines("R2 R3 sweep write");
      cp_write(32'h0040_0000, 8'(v % 2));
      e_ret = v % 2 == 1;
      host_rd(base + 1, rd, drv);  chk("R5 R8 stat after cp write", rd, e_ret ? 8'h00 : 8'h80);
    end

    dip_sel = 4'd8;
    for (int d = 0; d < 256; d++) begin
      host_wr(10'h210, 8'(d), 0, 1);
      e_l0 = d[0]; e_rst = d[1]; e_l1 = d[7];
      chk_lines("R3 R6 data pattern");
      cp_addr = 32'h0040_0000; #1;
      chk("R7 cp read", cp_rdata, {e_l1, 6'b0, e_l0});
    end

    host_wr(10'h210, 8'h83, 0, 1); e_l0 = 1; e_l1 = 1; e_rst = 1;
    chk_lines("R3 set all");
    host_wr(10'h211, 8'h00, 0, 1); chk_lines("R4 status port write ignored");
    host_wr(10'h210, 8'h00, 1, 1); chk_lines("R4 aen write ignored");
    host_wr(10'h212, 8'h00, 0, 1); chk_lines("R4 outside write ignored");
    isa_aen = 1; host_rd(10'h210, rd, drv); isa_aen = 0;
    chk("R2 aen read no drive", {drv, rd}, 0);

    @(negedge clk);
    isa_addr = 10'h210; isa_din = 8'h00; isa_iow_n = 0;
    repeat (4) begin @(negedge clk); chk_lines("R9 held strobe"); end
    isa_din = 8'h01;
    @(negedge clk); isa_iow_n = 1;
    @(negedge clk); isa_addr = '0;
    e_l0 = 1; e_l1 = 0; e_rst = 0;
    chk_lines("R9 capture on release");

    probes = '{32'h0040_0000, 32'h007F_FFFC, 32'h0040_0004, 32'h0040_0001,
               32'h0080_0000, 32'h0000_0000, 32'h00C0_0000, 32'h0140_0000};
    for (int p = 0; p < 8; p++) begin
      logic exp_hit;
      exp_hit = cp_hit_model(probes[p]);
      cp_addr = probes[p]; #1;
      chk("R7 mirror read", cp_rdata, exp_hit ? {e_l1, 6'b0, e_l0} : 8'h00);
      cp_write(probes[p], {7'h7F, ~e_ret});
      if (exp_hit) e_ret = ~e_ret;
      chk("R8 mirror write", cp_busy, e_ret);
    end

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; e_l0 = 0; e_l1 = 0; e_rst = 0; e_ret = 0;
    @(negedge clk);
    chk("R1 second reset", {cp_line0, cp_line1, cp_reset, cp_firq, cp_busy}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule